// File: doc/BRIEF.md
# Flag Offset Programming Interface

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full comparators use. It reads the four active-low controls: load, write enable, read enable and serial enable. From them it decides whether the current clock edge does one of four things: a storage access that is passed on to the FIFO core, a parallel write into an offset register, a parallel readback of an offset register, or a serial shift of one bit into the offsets. Each offset is `OFS_W` bits wide. It is stored as a low part of `LO_W` bits and a high part that holds the remaining bits.

The level of the load input during master reset selects the programming method. With load high, serial programming is chosen and both offsets start at 0x3FF. With load low, parallel programming is chosen and both offsets start at 0x07F. Parallel writes and parallel reads each step through the four parts with their own pointer. The offsets can be reprogrammed at any time after reset, and readback is always parallel. Both the write side and the read side of the offset logic run on one clock `clk`. The data interfaces have no back-pressure: every qualifying edge is accepted, and there is no ready signal. A readback word is marked by `rd_valid_o` for exactly one cycle.

Top module: `flag_offset_prog`

## Requirements
- R1: When `ld_i` is 1 at the last reset edge, `serial_mode_o` is 1 and both offsets equal 0x3FF after reset.
- R2: When `ld_i` is 0 at the last reset edge, `serial_mode_o` is 0 and both offsets equal 0x07F after reset.
- R3: In parallel mode, each edge with `ld_i`=1 and `wen_n_i`=0 writes to the part chosen by a write pointer. The pointer steps through 0 empty-low, 1 empty-high, 2 full-low, 3 full-high and then wraps to 0. A low part takes `din_i[LO_W-1:0]` and a high part takes `din_i[OFS_W-LO_W-1:0]`.
- R4: Each edge with `ld_i`=1 and `ren_n_i`=0 latches the part chosen by a read pointer into `rd_data_o`, zero-extended, and raises `rd_valid_o` for that one cycle. The read pointer uses the same four-step order and also wraps. When no readback occurs, `rd_valid_o` is 0 and `rd_data_o` keeps its value.
- R5: Parallel readback works in serial mode as well.
- R6: In serial mode, each edge with `ld_i`=1, `wen_n_i`=1, `ren_n_i`=1 and `sen_n_i`=0 shifts `sdin_i` into a 2*OFS_W-bit chain, LSB first. The k-th bit shifted in, counted from 0, ends at empty bit k when k<OFS_W and at full bit k-OFS_W otherwise. Each shift moves every bit already in the chain down by one place.
- R7: Parallel writes in serial mode, serial shifts in parallel mode, and edges with `ld_i`=1, `wen_n_i`=1, `ren_n_i`=1, `sen_n_i`=1 leave both offsets unchanged.
- R8: With `ld_i`=0, `mem_wr_o` = !`wen_n_i` and `mem_rd_o` = !`ren_n_i`, combinationally. The offsets stay unchanged and no readback occurs.
- R9: With `ld_i`=1, `mem_wr_o` and `mem_rd_o` are 0.
- R10: Master reset returns both pointers to slot 0, so the first write and the first read after reset use empty-low.
- R11: `serial_mode_o` changes only at reset, whatever `ld_i` does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous master reset, active low |
| ld_i | input | 1 | Load select; its level at reset picks the programming method |
| wen_n_i | input | 1 | Write enable, active low |
| ren_n_i | input | 1 | Read enable, active low |
| sen_n_i | input | 1 | Serial enable, active low |
| sdin_i | input | 1 | Serial offset bit |
| din_i | input | DATA_W | Parallel write data |
| mem_wr_o | output | 1 | Storage write strobe for the FIFO core |
| mem_rd_o | output | 1 | Storage read strobe for the FIFO core |
| rd_data_o | output | DATA_W | Readback word |
| rd_valid_o | output | 1 | Readback word valid, one cycle |
| empty_ofs_o | output | OFS_W | Assembled empty offset |
| full_ofs_o | output | OFS_W | Assembled full offset |
| serial_mode_o | output | 1 | 1 when serial programming was chosen at reset |

## Verification
The bench uses the default parameters: OFS_W=17, LO_W=16, DATA_W=18. With these values the high part is a single bit, so a write with all data bits set must land only bit 16. A full serial load is 34 shifts, which is short enough to run completely and then extend with one extra shift. The 18-bit bus leaves two data bits above every register, and the checks confirm that readback zero-fills them.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;
  // Register part addressed by the write and read pointers; the order is behaviour.
  typedef enum logic [1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } slot_e;

  typedef struct packed {
    logic mem_wr;
    logic mem_rd;
    logic reg_wr;
    logic reg_rd;
    logic shift;
  } op_t;
endpackage

// File: rtl/flag_ofs_decode.sv
module flag_ofs_decode
  import flag_ofs_pkg::*;
(
  input  logic ld,
  input  logic wen_n,
  input  logic ren_n,
  input  logic sen_n,
  input  logic serial_mode,
  output op_t  op
);
  always_comb begin
    op = '0;
    if (!ld) begin
      op.mem_wr = !wen_n;
      op.mem_rd = !ren_n;
    end else begin
      op.reg_wr = !wen_n && !serial_mode;
      op.reg_rd = !ren_n;
      op.shift  = wen_n && ren_n && !sen_n && serial_mode;
    end
  end
endmodule

// File: rtl/flag_ofs_regs.sv
module flag_ofs_regs
  import flag_ofs_pkg::*;
#(
  parameter int OFS_W  = 17,
  parameter int LO_W   = 16,
  parameter int DATA_W = 18,
  parameter logic [OFS_W-1:0] DEF_SER = 'h3FF,
  parameter logic [OFS_W-1:0] DEF_PAR = 'h07F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              reg_wr,
  input  logic              shift,
  input  logic              sdin,
  input  logic [DATA_W-1:0] din,
  output logic              serial_mode,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs
);
  localparam int HI_W = OFS_W - LO_W;
  localparam int CH_W = 2 * OFS_W;

  logic [CH_W-1:0] chain_q, chain_wr;
  slot_e           wr_ptr_q;
  logic            serial_q;
  logic [OFS_W-1:0] def_val;

  assign def_val = ld ? DEF_SER : DEF_PAR;

  // Parallel write image: only the addressed part is replaced.
  always_comb begin
    chain_wr = chain_q;
    case (wr_ptr_q)
      SLOT_E_LO: chain_wr[0 +: LO_W]             = din[LO_W-1:0];
      SLOT_E_HI: chain_wr[LO_W +: HI_W]          = din[HI_W-1:0];
      SLOT_F_LO: chain_wr[OFS_W +: LO_W]         = din[LO_W-1:0];
      default:   chain_wr[OFS_W + LO_W +: HI_W]  = din[HI_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serial_q <= ld;
      chain_q  <= {def_val, def_val};
      wr_ptr_q <= SLOT_E_LO;
    end else if (shift) begin
      chain_q <= {sdin, chain_q[CH_W-1:1]};
    end else if (reg_wr) begin
      chain_q  <= chain_wr;
      wr_ptr_q <= slot_e'(wr_ptr_q + 2'd1);
    end
  end

  assign serial_mode = serial_q;
  assign empty_ofs   = chain_q[OFS_W-1:0];
  assign full_ofs    = chain_q[CH_W-1:OFS_W];

  // R1 R2
  reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (chain_q == {2{(serial_q ? DEF_SER : DEF_PAR)}}));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr || shift) |=> $stable(chain_q));

  // R7
  method_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_q && !reg_wr) || (!serial_q && !shift));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(serial_q));
endmodule

// File: rtl/flag_ofs_readback.sv
module flag_ofs_readback
  import flag_ofs_pkg::*;
#(
  parameter int OFS_W  = 17,
  parameter int LO_W   = 16,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int HI_W = OFS_W - LO_W;

  slot_e             rd_ptr_q;
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    case (rd_ptr_q)
      SLOT_E_LO: sel_word = DATA_W'(empty_ofs[LO_W-1:0]);
      SLOT_E_HI: sel_word = DATA_W'(empty_ofs[LO_W +: HI_W]);
      SLOT_F_LO: sel_word = DATA_W'(full_ofs[LO_W-1:0]);
      default:   sel_word = DATA_W'(full_ofs[LO_W +: HI_W]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= SLOT_E_LO;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) begin
        rd_data  <= sel_word;
        rd_ptr_q <= slot_e'(rd_ptr_q + 2'd1);
      end
    end
  end

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (!rd_valid && $stable(rd_data)));
endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog
  import flag_ofs_pkg::*;
#(
  parameter int OFS_W  = 17,
  parameter int LO_W   = 16,
  parameter int DATA_W = 18,
  parameter logic [OFS_W-1:0] DEF_SER = 'h3FF,
  parameter logic [OFS_W-1:0] DEF_PAR = 'h07F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic              wen_n_i,
  input  logic              ren_n_i,
  input  logic              sen_n_i,
  input  logic              sdin_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              mem_wr_o,
  output logic              mem_rd_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [OFS_W-1:0]  empty_ofs_o,
  output logic [OFS_W-1:0]  full_ofs_o,
  output logic              serial_mode_o
);
  op_t op;

  flag_ofs_decode u_decode (
    .ld          (ld_i),
    .wen_n       (wen_n_i),
    .ren_n       (ren_n_i),
    .sen_n       (sen_n_i),
    .serial_mode (serial_mode_o),
    .op          (op)
  );

  flag_ofs_regs #(
    .OFS_W   (OFS_W),
    .LO_W    (LO_W),
    .DATA_W  (DATA_W),
    .DEF_SER (DEF_SER),
    .DEF_PAR (DEF_PAR)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld          (ld_i),
    .reg_wr      (op.reg_wr),
    .shift       (op.shift),
    .sdin        (sdin_i),
    .din         (din_i),
    .serial_mode (serial_mode_o),
    .empty_ofs   (empty_ofs_o),
    .full_ofs    (full_ofs_o)
  );

  flag_ofs_readback #(
    .OFS_W  (OFS_W),
    .LO_W   (LO_W),
    .DATA_W (DATA_W)
  ) u_readback (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (op.reg_rd),
    .empty_ofs (empty_ofs_o),
    .full_ofs  (full_ofs_o),
    .rd_data   (rd_data_o),
    .rd_valid  (rd_valid_o)
  );

  assign mem_wr_o = op.mem_wr;
  assign mem_rd_o = op.mem_rd;

  // R8
  mem_keeps_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> ($stable(empty_ofs_o) && $stable(full_ofs_o) && !rd_valid_o));
endmodule

// File: tb/flag_offset_prog_bench.sv
`timescale 1ns/1ps
module flag_offset_prog_bench;
  localparam int OFS_W  = 17;
  localparam int DATA_W = 18;

  logic clk = 1'b0;
  logic rst_n, ld, wen_n, ren_n, sen_n, sdin;
  logic [DATA_W-1:0] din;
  logic mem_wr, mem_rd, rd_valid, serial_mode;
  logic [DATA_W-1:0] rd_data;
  logic [OFS_W-1:0] e_ofs, f_ofs;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  flag_offset_prog u_flag_offset_prog (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .wen_n_i(wen_n), .ren_n_i(ren_n),
    .sen_n_i(sen_n), .sdin_i(sdin), .din_i(din), .mem_wr_o(mem_wr),
    .mem_rd_o(mem_rd), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .empty_ofs_o(e_ofs), .full_ofs_o(f_ofs), .serial_mode_o(serial_mode)
  );

  typedef struct packed {
    logic ld; logic wen_n; logic ren_n; logic sen_n;
    logic exp_wr; logic exp_rd; logic exp_rv;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0},
    '{1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b1},
    '{1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1},
    '{1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld = 1'b0; wen_n = 1'b1; ren_n = 1'b1; sen_n = 1'b1; sdin = 1'b0; din = '0;
  endtask

  // Called at a negedge; returns at the next negedge with controls idle.
  task automatic step(input logic l, input logic w, input logic r, input logic s,
                      input logic b, input logic [DATA_W-1:0] d);
    ld = l; wen_n = w; ren_n = r; sen_n = s; sdin = b; din = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset(input logic l);
    idle();
    rst_n = 1'b0; ld = l;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; idle();
    @(negedge clk);
  endtask

  task automatic pwrite(input logic [DATA_W-1:0] d);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, d);
  endtask

  task automatic pread(input logic [63:0] exp, input string req);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    chk(req, rd_valid, 1);
    chk(req, rd_data, exp);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [2*OFS_W-1:0] pat;
    rst_n = 1'b0;
    idle();
    @(negedge clk);

    // R2 parallel defaults
    do_reset(1'b0);
    chk("R2 mode", serial_mode, 0);
    chk("R2 empty", e_ofs, 'h07F);
    chk("R2 full", f_ofs, 'h07F);
    chk("R4 valid at reset", rd_valid, 0);

    // Decode vectors (R8 R9 R4)
    foreach (VECS[i]) begin
      ld = VECS[i].ld; wen_n = VECS[i].wen_n; ren_n = VECS[i].ren_n; sen_n = VECS[i].sen_n;
      #1;
      chk(VECS[i].ld ? "R9 mem_wr" : "R8 mem_wr", mem_wr, VECS[i].exp_wr);
      chk(VECS[i].ld ? "R9 mem_rd" : "R8 mem_rd", mem_rd, VECS[i].exp_rd);
      @(negedge clk);
      chk("R4 valid after vector", rd_valid, VECS[i].exp_rv);
    end

    // R3 parallel write order and wrap
    do_reset(1'b0);
    pwrite('h0A5A5);
    pwrite('h3FFFF);
    pwrite('h01234);
    pwrite('h00000);
    chk("R3 empty", e_ofs, 'h1A5A5);
    chk("R3 full", f_ofs, 'h01234);
    pwrite('h0BEEF);
    chk("R3 wrap", e_ofs, 'h1BEEF);

    // R7 serial shift ignored in parallel mode
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
    chk("R7 empty", e_ofs, 'h1BEEF);
    chk("R7 full", f_ofs, 'h01234);

    // R4 readback order, wrap, hold
    pread('h0BEEF, "R4 slot0");
    pread('h00001, "R4 slot1");
    pread('h01234, "R4 slot2");
    pread('h00000, "R4 slot3");
    pread('h0BEEF, "R4 wrap");
    @(negedge clk);
    chk("R4 idle valid", rd_valid, 0);
    chk("R4 idle hold", rd_data, 'h0BEEF);

    // R8 storage ops leave offsets, no readback
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 'h3FFFF);
    chk("R8 no readback", rd_valid, 0);
    chk("R8 empty", e_ofs, 'h1BEEF);

    // R10 pointers back to slot 0 after reset
    pwrite('h00111);
    do_reset(1'b0);
    pwrite('h00042);
    chk("R10 write slot", e_ofs, 'h00042);
    chk("R10 full kept", f_ofs, 'h07F);
    pread('h00042, "R10 read slot");

    // R1 serial defaults
    do_reset(1'b1);
    chk("R1 mode", serial_mode, 1);
    chk("R1 empty", e_ofs, 'h3FF);
    chk("R1 full", f_ofs, 'h3FF);

    // R7 parallel write ignored in serial mode, no-op combination
    pwrite('h01111);
    chk("R7 par in serial", e_ofs, 'h3FF);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R7 no-op", f_ofs, 'h3FF);

    // R6 full serial load
    pat = {17'h0BEEF, 17'h15A3C};
    for (int k = 0; k < 2*OFS_W; k++) step(1'b1, 1'b1, 1'b1, 1'b0, pat[k], '0);
    chk("R6 empty", e_ofs, 'h15A3C);
    chk("R6 full", f_ofs, 'h0BEEF);
    chk("R11 mode kept", serial_mode, 1);

    // R5 readback in serial mode
    pread('h05A3C, "R5 slot0");
    pread('h00001, "R5 slot1");
    pread('h0BEEF, "R5 slot2");
    pread('h00000, "R5 slot3");

    // R6 one extra shift moves the chain down
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
    chk("R6 shift empty", e_ofs, 'h1AD1E);
    chk("R6 shift full", f_ofs, 'h15F77);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule